// File: doc/BRIEF.md
# I2S Slave Start Synchronizer

This block decides the first bit-clock cycle on which an audio serial port working as a slave may begin moving data. The block runs directly on the externally supplied bit clock. It samples the word-select line (WS) on every bit-clock edge. When the configuration makes the port an enabled I2S slave and the chosen start condition is met, it raises a one-cycle start pulse. It also sets a running flag, and that flag gates the downstream serial data engine.

There are two start policies. In the edge policy, the block waits until it has taken a WS sample and then sees WS move to the qualifying level on a later sample. In the level policy, WS only has to be at the qualifying level on any enabled sample. The qualifying level is low for the Philips standard and high for every other standard. The mode bit, which selects I2S or SPI, is captured only while the port is disabled.

Top module: `i2s_slave_start_sync`

## Requirements
- R1: After reset, `running` and `start_pulse` are both 0.
- R2: With `async_start_en`=0 and a non-Philips standard (`std_sel` other than 2'b00), a start happens on the first enabled edge where WS is sampled 1 and the previous enabled sample was 0. `running` and `start_pulse` are 1 right after that edge.
- R3: With `async_start_en`=0 and the Philips standard (`std_sel`=2'b00), only a WS change from 1 to 0 between consecutive enabled samples starts the port. A change from 0 to 1 does not start it.
- R4: In edge policy, the first enabled sample has no predecessor. If WS is already at the qualifying level on that sample, the port does not start.
- R5: With `async_start_en`=1 and a non-Philips standard, the port starts on the first enabled edge where WS is sampled 1. This includes the very first enabled edge.
- R6: With `async_start_en`=1 and the Philips standard, the port starts on the first enabled edge where WS is sampled 0. A WS of 1 does not start it.
- R7: `start_pulse` is high for exactly one cycle per start. While enabled, `running` stays 1 whatever WS does.
- R8: An edge with `enable`=0 clears `running` and `start_pulse` and discards the stored WS sample. The first enabled sample after that counts as having no predecessor.
- R9: The port never starts while `slave_sel`=0 or while the captured mode is SPI. Mode value 1 means I2S and 0 means SPI.
- R10: `i2s_mode` is captured only on edges where `enable`=0. Changes made while enabled have no effect until after the port has been disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the external master; block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable |
| slave_sel | input | 1 | 1 selects slave operation |
| i2s_mode | input | 1 | 1 = I2S, 0 = SPI; captured while disabled |
| async_start_en | input | 1 | 1 = level policy, 0 = edge policy |
| std_sel | input | STD_W | Audio standard; 2'b00 is Philips |
| ws | input | 1 | Word-select line |
| start_pulse | output | 1 | One-cycle start indication |
| running | output | 1 | Transfer allowed; gates the data engine |

## Verification
The bench enables the port while WS already sits at the qualifying level. A design that treats reset-state history as a real sample would start falsely there. It also disables and re-enables the port with WS changing across the gap, which exposes a stored sample that was not discarded. The Philips cases send the wrong-direction edge and the wrong level first; a design with the polarity inverted starts early on those and then misses the real condition. Mode changes made while enabled, and a non-slave configuration, both have to hold the port idle. WS toggling after a start must neither drop `running` nor produce a second pulse.

// File: rtl/i2s_start_pkg.sv
package i2s_start_pkg;
  localparam int unsigned DEF_STD_W = 2;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } start_state_e;
endpackage

// File: rtl/i2s_mode_latch.sv
module i2s_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic mode_in,
  output logic mode_q
);
  // Captures the mode bit only while the port is disabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else if (!enable) mode_q <= mode_in;
  end
endmodule

// File: rtl/i2s_ws_sampler.sv
module i2s_ws_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic ws,
  output logic ws_prev,
  output logic prev_vld
);
  // Holds the previous enabled WS sample; cleared whenever disarmed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev  <= 1'b0;
      prev_vld <= 1'b0;
    end else if (!armed) begin
      ws_prev  <= 1'b0;
      prev_vld <= 1'b0;
    end else begin
      ws_prev  <= ws;
      prev_vld <= 1'b1;
    end
  end
endmodule

// File: rtl/i2s_start_qual.sv
module i2s_start_qual (
  input  logic ws,
  input  logic ws_prev,
  input  logic prev_vld,
  input  logic level_policy,
  input  logic philips,
  output logic hit
);
  logic target_lvl;
  logic level_hit;
  logic edge_hit;

  always_comb begin
    target_lvl = ~philips;
    level_hit  = (ws == target_lvl);
    edge_hit   = prev_vld && (ws_prev != target_lvl) && level_hit;
    hit        = level_policy ? level_hit : edge_hit;
  end
endmodule

// File: rtl/i2s_start_ctrl.sv
module i2s_start_ctrl
  import i2s_start_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic hit,
  output logic running,
  output logic start_pulse
);
  start_state_e state_q, state_d;
  logic         pulse_d;

  always_comb begin
    state_d = state_q;
    pulse_d = 1'b0;
    if (!armed) begin
      state_d = ST_WAIT;
    end else if (state_q == ST_WAIT && hit) begin
      state_d = ST_RUN;
      pulse_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_WAIT;
      start_pulse <= 1'b0;
    end else begin
      state_q     <= state_d;
      start_pulse <= pulse_d;
    end
  end

  assign running = (state_q == ST_RUN);
endmodule

// File: rtl/i2s_slave_start_sync.sv
module i2s_slave_start_sync
  import i2s_start_pkg::*;
#(
  parameter int unsigned          STD_W        = DEF_STD_W,
  parameter logic [STD_W-1:0]     PHILIPS_CODE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             slave_sel,
  input  logic             i2s_mode,
  input  logic             async_start_en,
  input  logic [STD_W-1:0] std_sel,
  input  logic             ws,
  output logic             start_pulse,
  output logic             running
);
  logic mode_q;
  logic armed;
  logic philips;
  logic ws_prev;
  logic prev_vld;
  logic hit;

  i2s_mode_latch u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .mode_in (i2s_mode),
    .mode_q  (mode_q)
  );

  assign armed   = enable && slave_sel && mode_q;
  assign philips = (std_sel == PHILIPS_CODE);

  i2s_ws_sampler u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (armed),
    .ws       (ws),
    .ws_prev  (ws_prev),
    .prev_vld (prev_vld)
  );

  i2s_start_qual u_qual (
    .ws           (ws),
    .ws_prev      (ws_prev),
    .prev_vld     (prev_vld),
    .level_policy (async_start_en),
    .philips      (philips),
    .hit          (hit)
  );

  i2s_start_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .armed       (armed),
    .hit         (hit),
    .running     (running),
    .start_pulse (start_pulse)
  );
endmodule

// File: rtl/i2s_slave_start_sync_chk.sv
module i2s_slave_start_sync_chk #(
  parameter int unsigned      STD_W        = 2,
  parameter logic [STD_W-1:0] PHILIPS_CODE = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             slave_sel,
  input logic             async_start_en,
  input logic [STD_W-1:0] std_sel,
  input logic             ws,
  input logic             mode_q,
  input logic             running,
  input logic             start_pulse
);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  a_r7_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (running && enable && slave_sel) |=> running);

  a_r2_rise_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> start_pulse);

  a_r8_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!running && !start_pulse));

  a_r9_no_slave_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_sel || !mode_q) |=> !running);

  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(mode_q));

  a_r5_level_high: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && slave_sel && mode_q && async_start_en && std_sel != PHILIPS_CODE
     && ws && !running) |=> (running && start_pulse));

  a_r6_level_low: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && slave_sel && mode_q && async_start_en && std_sel == PHILIPS_CODE
     && !ws && !running) |=> (running && start_pulse));
endmodule

bind i2s_slave_start_sync i2s_slave_start_sync_chk #(
  .STD_W(STD_W), .PHILIPS_CODE(PHILIPS_CODE)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .enable         (enable),
  .slave_sel      (slave_sel),
  .async_start_en (async_start_en),
  .std_sel        (std_sel),
  .ws             (ws),
  .mode_q         (mode_q),
  .running        (running),
  .start_pulse    (start_pulse)
);

// File: tb/i2s_slave_start_sync_tb.sv
module i2s_slave_start_sync_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       slave_sel = 1'b0;
  logic       i2s_mode = 1'b0;
  logic       async_start_en = 1'b0;
  logic [1:0] std_sel = 2'b01;
  logic       ws = 1'b0;
  logic       start_pulse;
  logic       running;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    logic  run;
    logic  pulse;
    string req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  i2s_slave_start_sync u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .slave_sel(slave_sel),
    .i2s_mode(i2s_mode), .async_start_en(async_start_en), .std_sel(std_sel),
    .ws(ws), .start_pulse(start_pulse), .running(running)
  );

  function automatic void check(logic run_e, logic pulse_e, string req);
    n_checks++;
    if (running !== run_e || start_pulse !== pulse_e) begin
      n_fail++;
      $display("FAIL %s: running=%b start=%b expected running=%b start=%b",
               req, running, start_pulse, run_e, pulse_e);
    end
  endfunction

  // Monitor: pops one expectation per clock, sampled at the falling edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.run, e.pulse, e.req);
    end
  end

  // Driver: applies inputs for one edge and queues the expected result.
  task automatic step(logic en, logic w, logic run_e, logic pulse_e, string req);
    exp_t e;
    @(negedge clk);
    enable = en;
    ws     = w;
    @(posedge clk);
    e.run = run_e; e.pulse = pulse_e; e.req = req;
    sb.push_back(e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: running=%b expected completion", running);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, 1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, 1'b0, "R1");

    slave_sel = 1'b1; i2s_mode = 1'b1; std_sel = 2'b01; async_start_en = 1'b0;
    step(0, 0, 0, 0, "R1");

    // R2 rising edge start, R7 hold and single pulse
    step(1, 0, 0, 0, "R2");
    step(1, 0, 0, 0, "R2");
    step(1, 1, 1, 1, "R2");
    step(1, 1, 1, 0, "R7");
    step(1, 0, 1, 0, "R7");
    step(1, 1, 1, 0, "R7");
    step(0, 1, 0, 0, "R8");

    // R4 already high at first sample
    step(1, 1, 0, 0, "R4");
    step(1, 1, 0, 0, "R4");
    step(1, 0, 0, 0, "R4");
    step(1, 1, 1, 1, "R2");
    step(0, 1, 0, 0, "R8");

    // R8 stored sample discarded across disable
    step(1, 0, 0, 0, "R8");
    step(0, 0, 0, 0, "R8");
    step(1, 1, 0, 0, "R8");
    step(0, 1, 0, 0, "R8");

    // R3 Philips edge policy
    std_sel = 2'b00;
    step(1, 0, 0, 0, "R3");
    step(1, 1, 0, 0, "R3");
    step(1, 0, 1, 1, "R3");
    step(1, 1, 1, 0, "R7");
    step(0, 0, 0, 0, "R8");

    // R5 level policy, non-Philips
    std_sel = 2'b10; async_start_en = 1'b1;
    step(1, 0, 0, 0, "R5");
    step(1, 1, 1, 1, "R5");
    step(0, 1, 0, 0, "R8");
    step(1, 1, 1, 1, "R5");
    step(0, 0, 0, 0, "R8");

    // R6 level policy, Philips
    std_sel = 2'b00;
    step(1, 1, 0, 0, "R6");
    step(1, 0, 1, 1, "R6");
    step(0, 0, 0, 0, "R8");

    // R9 not slave, then SPI mode
    std_sel = 2'b01; slave_sel = 1'b0;
    step(1, 1, 0, 0, "R9");
    step(1, 1, 0, 0, "R9");
    step(0, 1, 0, 0, "R9");
    slave_sel = 1'b1; i2s_mode = 1'b0;
    step(0, 1, 0, 0, "R9");
    step(1, 1, 0, 0, "R9");

    // R10 mode write while enabled ignored
    i2s_mode = 1'b1;
    step(1, 1, 0, 0, "R10");
    step(1, 1, 0, 0, "R10");
    step(0, 1, 0, 0, "R10");
    step(1, 1, 1, 1, "R10");
    i2s_mode = 1'b0;
    step(1, 1, 1, 0, "R10");
    step(1, 0, 1, 0, "R10");
    step(0, 0, 0, 0, "R8");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule